// File: doc/BRIEF.md
# Wake-Up Timer Counter with Snapshot

This block is an elapsed-time counter that runs in the always-on 32 kHz domain. It advances once for each pulse of a prescaled, gated time-base enable. The count is held as several 16-bit words (three by default) that software treats as one wide value. A matching set of alarm words is compared with the count. When the alarm is enabled and the two match, a sticky status bit is set. That bit drives a wake request toward the power-management controller, so the request survives while the processor is powered down.

Software can freeze a coherent copy of the whole count by writing a fixed key to a gateway register. The copy stays in the snapshot words until the key is written again.

A power-on reset clears every register and raises a fail flag. The flag tells software that the time base was lost, so it must reload the count. Register writes arrive already synchronized to this clock as single-cycle strobes. Reads are combinational on a separate read address.

Top module: `wake_timer_core`

## Requirements
- R1: After reset every register reads zero, except the control register, which reads 0x0004 because its fail flag (bit 2) is set. `wake_irq` is low.
- R2: The control register is at address 0. Bit 0 enables counting and bit 1 enables the alarm. Any write to this address clears the fail flag.
- R3: The count words are at addresses 3, 4 and 5, with address 3 holding the least significant word. On each `tick` pulse the count increases by one while bit 0 of the control register is set. Without a tick, or while that bit is clear, the count does not change.
- R4: A write to a count word does not change the count at once. On the next tick the written words replace their part of the count, and the count does not increment on that tick. This happens whether or not counting is enabled.
- R5: When the count is all ones, an enabled tick wraps it to zero and sets the overflow bit (status register, address 1, bit 1). Writing 1 to that bit clears it.
- R6: A write of 0x7627 to the gateway register (address 2) copies every count word into the snapshot words (addresses 9, 10 and 11, least significant first) in the same clock edge.
- R7: A write of any other value to the gateway register has no effect. Between key writes, the snapshot words hold their value while the count keeps moving.
- R8: The alarm words are at addresses 6, 7 and 8, least significant first. When the alarm is enabled and the count equals the alarm value, status bit 0 is set one clock later.
- R9: Status bit 0 is sticky and is cleared only by writing 1 to it. `wake_irq` is high exactly when status bit 0 and the alarm-enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz domain clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| tick | input | 1 | Prescaled time-base enable, one cycle per count step |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Read data for `rd_addr` (zero when unmapped) |
| wake_irq | output | 1 | Sticky alarm request to the wake controller |

## Verification
An increment that is lost or doubled shows up on the least significant count word at the first read after the faulty tick. A load that is applied early shows up before any tick has happened. A snapshot that follows the live count instead of holding is exposed by ticking between key writes and reading the snapshot back. A sticky bit that decays, or one that ignores the enable, shows on `wake_irq` within one cycle of the tick that matches the alarm or of the following control write.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
   localparam int CTRL_ADDR = 0;
   localparam int STAT_ADDR = 1;
   localparam int GATE_ADDR = 2;
   localparam int CNT_BASE  = 3;

   localparam int CTRL_RUN_BIT  = 0;
   localparam int CTRL_ALM_BIT  = 1;
   localparam int STAT_HIT_BIT  = 0;
   localparam int STAT_WRAP_BIT = 1;

   typedef struct packed {
      logic fail;
      logic alm_en;
      logic cnt_en;
   } ctrl_t;
endpackage

// File: rtl/wkt_counter.sv
module wkt_counter #(
   parameter int WORD_W  = 16,
   parameter int N_WORDS = 3,
   localparam int CW     = WORD_W * N_WORDS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               run,
   input  logic [N_WORDS-1:0] ld_stb,
   input  logic [WORD_W-1:0]  ld_val,
   output logic [CW-1:0]      count,
   output logic               pend_any,
   output logic               wrap
);
   logic [N_WORDS-1:0] pend;
   logic [CW-1:0]      merged;

   for (genvar i = 0; i < N_WORDS; i++) begin : g_word
      logic [WORD_W-1:0] hold;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend[i] <= 1'b0;
            hold    <= '0;
         end else begin
            if (tick) pend[i] <= 1'b0;
            if (ld_stb[i]) begin
               pend[i] <= 1'b1;
               hold    <= ld_val;
            end
         end
      end
      assign merged[i*WORD_W +: WORD_W] = pend[i] ? hold : count[i*WORD_W +: WORD_W];
   end

   assign pend_any = |pend;
   assign wrap     = tick && run && !pend_any && (&count);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (tick) begin
         if (pend_any)  count <= merged;
         else if (run)  count <= count + CW'(1);
      end
   end
endmodule

// File: rtl/wkt_snapshot.sv
module wkt_snapshot #(
   parameter int CW = 48
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic [CW-1:0] count,
   output logic [CW-1:0] snap
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    snap <= '0;
      else if (take) snap <= count;
   end
endmodule

// File: rtl/wkt_alarm.sv
module wkt_alarm #(
   parameter int CW = 48
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          clear,
   input  logic [CW-1:0] count,
   input  logic [CW-1:0] target,
   output logic          status
);
   logic hit;
   assign hit = enable && (count == target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   status <= 1'b0;
      else if (hit) status <= 1'b1;
      else if (clear) status <= 1'b0;
   end
endmodule

// File: rtl/wake_timer_core.sv
module wake_timer_core
   import wkt_pkg::*;
#(
   parameter int              WORD_W   = 16,
   parameter int              N_WORDS  = 3,
   parameter int              ADDR_W   = 4,
   parameter logic [WORD_W-1:0] SNAP_KEY = 16'h7627
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data,
   output logic              wake_irq
);
   localparam int CW        = WORD_W * N_WORDS;
   localparam int ALM_BASE  = CNT_BASE + N_WORDS;
   localparam int SNAP_BASE = ALM_BASE + N_WORDS;
   localparam int LAST_ADDR = SNAP_BASE + N_WORDS - 1;

   if (N_WORDS < 1) begin : g_bad_words
      $fatal(1, "N_WORDS must be at least 1");
   end
   if (WORD_W < 3) begin : g_bad_width
      $fatal(1, "WORD_W too narrow for control bits");
   end
   if (LAST_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $fatal(1, "ADDR_W too small for register map");
   end

   ctrl_t              ctrl;
   logic               wrap_st;
   logic               alm_st;
   logic [CW-1:0]      alarm_q;
   logic [CW-1:0]      count_q;
   logic [CW-1:0]      snap_q;
   logic               pend_any;
   logic               wrap;
   logic [N_WORDS-1:0] cnt_ld;
   logic [N_WORDS-1:0] alm_ld;

   logic ctrl_wr, stat_wr, key_wr;
   assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
   assign stat_wr = wr_en && (wr_addr == ADDR_W'(STAT_ADDR));
   assign key_wr  = wr_en && (wr_addr == ADDR_W'(GATE_ADDR)) && (wr_data == SNAP_KEY);

   for (genvar i = 0; i < N_WORDS; i++) begin : g_dec
      assign cnt_ld[i] = wr_en && (wr_addr == ADDR_W'(CNT_BASE + i));
      assign alm_ld[i] = wr_en && (wr_addr == ADDR_W'(ALM_BASE + i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         alarm_q[i*WORD_W +: WORD_W] <= '0;
         else if (alm_ld[i]) alarm_q[i*WORD_W +: WORD_W] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl    <= '{fail: 1'b1, alm_en: 1'b0, cnt_en: 1'b0};
         wrap_st <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            ctrl.cnt_en <= wr_data[CTRL_RUN_BIT];
            ctrl.alm_en <= wr_data[CTRL_ALM_BIT];
            ctrl.fail   <= 1'b0;
         end
         if (wrap)                                  wrap_st <= 1'b1;
         else if (stat_wr && wr_data[STAT_WRAP_BIT]) wrap_st <= 1'b0;
      end
   end

   wkt_counter #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(ctrl.cnt_en),
      .ld_stb(cnt_ld), .ld_val(wr_data), .count(count_q),
      .pend_any(pend_any), .wrap(wrap)
   );

   wkt_snapshot #(.CW(CW)) u_snap (
      .clk(clk), .rst_n(rst_n), .take(key_wr), .count(count_q), .snap(snap_q)
   );

   wkt_alarm #(.CW(CW)) u_alm (
      .clk(clk), .rst_n(rst_n), .enable(ctrl.alm_en),
      .clear(stat_wr && wr_data[STAT_HIT_BIT]),
      .count(count_q), .target(alarm_q), .status(alm_st)
   );

   assign wake_irq = alm_st && ctrl.alm_en;

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(CTRL_ADDR)) rd_data = WORD_W'(ctrl);
      if (rd_addr == ADDR_W'(STAT_ADDR)) rd_data = WORD_W'({wrap_st, alm_st});
      for (int i = 0; i < N_WORDS; i++) begin
         if (rd_addr == ADDR_W'(CNT_BASE + i))  rd_data = count_q[i*WORD_W +: WORD_W];
         if (rd_addr == ADDR_W'(ALM_BASE + i))  rd_data = alarm_q[i*WORD_W +: WORD_W];
         if (rd_addr == ADDR_W'(SNAP_BASE + i)) rd_data = snap_q[i*WORD_W +: WORD_W];
      end
   end
endmodule

// File: rtl/wkt_checker.sv
module wkt_checker
   import wkt_pkg::*;
#(
   parameter int              WORD_W   = 16,
   parameter int              N_WORDS  = 3,
   parameter int              ADDR_W   = 4,
   parameter logic [WORD_W-1:0] SNAP_KEY = 16'h7627,
   localparam int             CW       = WORD_W * N_WORDS
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [WORD_W-1:0] wr_data,
   input logic [CW-1:0]     count,
   input logic [CW-1:0]     snap,
   input logic              cnt_en,
   input logic              pend_any,
   input logic              fail,
   input logic              wake_irq
);
   logic key_wr, ctrl_wr, hit_clr;
   assign key_wr  = wr_en && (wr_addr == ADDR_W'(GATE_ADDR)) && (wr_data == SNAP_KEY);
   assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
   assign hit_clr = wr_en && (wr_addr == ADDR_W'(STAT_ADDR)) && wr_data[STAT_HIT_BIT];

   // R3
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count));
   // R3
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick && cnt_en && !pend_any |=> count == ($past(count) + CW'(1)));
   // R6
   snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_wr |=> snap == $past(count));
   // R7
   snap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !key_wr |=> $stable(snap));
   // R9
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq && !hit_clr && !ctrl_wr |=> wake_irq);
   // R2
   fail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fail) |-> $past(ctrl_wr));
endmodule

bind wake_timer_core wkt_checker #(
   .WORD_W(WORD_W), .N_WORDS(N_WORDS), .ADDR_W(ADDR_W), .SNAP_KEY(SNAP_KEY)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .count(count_q), .snap(snap_q), .cnt_en(ctrl.cnt_en),
   .pend_any(pend_any), .fail(ctrl.fail), .wake_irq(wake_irq)
);

// File: tb/wake_timer_core_tb.sv
`timescale 1ns/1ps
module wake_timer_core_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        wake_irq;
   int          n_chk = 0;
   int          n_err = 0;

   always #2.5 clk = ~clk;

   wake_timer_core u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .wake_irq(wake_irq)
   );

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(int a, logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(string req, int a, logic [15:0] exp);
      rd_addr = 4'(a);
      #1;
      check(req, rd_data, exp);
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
      @(negedge clk);
   endtask

   task automatic t_reset;
      rd_chk("R1 ctrl", 0, 16'h0004);
      rd_chk("R1 cnt0", 3, 16'h0000);
      rd_chk("R1 snap0", 9, 16'h0000);
      check("R1 irq", 16'(wake_irq), 16'h0);
   endtask

   task automatic t_count;
      wr(0, 16'h0001);
      rd_chk("R2 fail cleared", 0, 16'h0001);
      ticks(5);
      rd_chk("R3 count 5", 3, 16'd5);
      wr(0, 16'h0000);
      ticks(3);
      rd_chk("R3 held when disabled", 3, 16'd5);
   endtask

   task automatic t_load;
      wr(3, 16'h1234); wr(4, 16'hABCD); wr(5, 16'h0001);
      rd_chk("R4 not yet loaded", 3, 16'd5);
      ticks(1);
      rd_chk("R4 word0", 3, 16'h1234);
      rd_chk("R4 word1", 4, 16'hABCD);
      rd_chk("R4 word2", 5, 16'h0001);
      wr(0, 16'h0001);
      ticks(2);
      rd_chk("R3 count after load", 3, 16'h1236);
   endtask

   task automatic t_wrap;
      wr(3, 16'hFFFF); wr(4, 16'hFFFF); wr(5, 16'hFFFF);
      ticks(1);
      rd_chk("R4 no increment on load", 5, 16'hFFFF);
      ticks(1);
      rd_chk("R5 wrap word0", 3, 16'h0000);
      rd_chk("R5 wrap word2", 5, 16'h0000);
      rd_chk("R5 overflow bit", 1, 16'h0002);
      wr(1, 16'h0002);
      rd_chk("R5 overflow cleared", 1, 16'h0000);
   endtask

   task automatic t_snap;
      ticks(4);
      wr(2, 16'h7627);
      rd_chk("R6 snap0", 9, 16'd4);
      rd_chk("R6 snap1", 10, 16'd0);
      ticks(3);
      rd_chk("R7 snap held", 9, 16'd4);
      wr(2, 16'h1234);
      rd_chk("R7 bad key", 9, 16'd4);
      wr(2, 16'h7626);
      rd_chk("R7 near key", 9, 16'd4);
      wr(2, 16'h7627);
      rd_chk("R6 resnap", 9, 16'd7);
   endtask

   task automatic t_alarm;
      wr(6, 16'd10); wr(7, 16'd0); wr(8, 16'd0);
      wr(0, 16'h0003);
      ticks(2);
      check("R8 no early irq", 16'(wake_irq), 16'h0);
      rd_chk("R8 status clear", 1, 16'h0000);
      ticks(1);
      check("R8 irq at match", 16'(wake_irq), 16'h1);
      rd_chk("R8 status set", 1, 16'h0001);
      ticks(2);
      check("R9 sticky past match", 16'(wake_irq), 16'h1);
      wr(1, 16'h0002);
      check("R9 other bit no clear", 16'(wake_irq), 16'h1);
      wr(0, 16'h0001);
      check("R9 gated by enable", 16'(wake_irq), 16'h0);
      rd_chk("R9 status kept", 1, 16'h0001);
      wr(1, 16'h0001);
      rd_chk("R9 w1c", 1, 16'h0000);
      wr(0, 16'h0003);
      check("R9 stays low", 16'(wake_irq), 16'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_count;
      t_load;
      t_wrap;
      t_snap;
      t_alarm;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #100000;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule